// File: doc/BRIEF.md
# Configurable-Sign 8x8 Multiplier

This block multiplies two 8-bit operands and returns a 16-bit product with no clock. It builds one row for each bit of operand `a`: the row is `b` gated by that bit and moved left by the bit's index. It then adds all the rows together.

Two mode pins set how each operand is read, either as an unsigned value or as a two's-complement value. All four combinations give the exact 16-bit product. Signedness is handled inside the row sum. The rows are sign-extended when `b` is signed, and the row for the top bit of `a` is subtracted when `a` is signed. No operand is negated before or after the sum.

The block is purely combinational. A caller that needs timing closure adds its own registers around it.

Top module: `cfg_sign_mult`

## Requirements
- R1: With `a_signed=0` and `b_signed=0`, `p` equals the unsigned product `a*b`. Examples: 255*255 gives 16'hFE01, and 128*2 gives 16'h0100.
- R2: With `a_signed=0` and `b_signed=1`, `b` is read as two's complement, so every row is sign-extended. `p` is the 16-bit two's-complement product. Examples: 255*(-1) gives 16'hFF01, and 2*(-128) gives 16'hFF00.
- R3: With `a_signed=1` and `b_signed=0`, the row for `a[7]` carries weight -128 and is subtracted. Examples: (-1)*255 gives 16'hFF01, and (-128)*255 gives 16'h8080.
- R4: With both mode pins at 1, `p` is the signed product. Examples: (-128)*(-128) gives 16'h4000, (-128)*127 gives 16'hC080, and (-1)*(-1) gives 16'h0001.
- R5: When either operand is zero, `p` is 16'h0000 in every mode.
- R6: `p` follows a change of the inputs with no clock edge in between.
- R7: A mode pin has no effect when the MSB of its operand is 0. Example: 127*255 with `b` unsigned gives 16'h7E81 whether `a_signed` is 0 or 1.
- R8: With both operands signed and both nonzero, `p[15]` equals `a[7]` XOR `b[7]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Operand whose bits select the rows |
| b | input | 8 | Operand that is gated into each row |
| a_signed | input | 1 | 1: read `a` as two's complement |
| b_signed | input | 1 | 1: read `b` as two's complement |
| p | output | 16 | Product |

## Verification
The embedded immediate assertions check every input change that settles to known values. They compare `p` with an independent extended-width multiply in each mode (R1 to R4), and they also check the zero-operand result (R5) and the product sign in signed mode (R8). Three properties depend on stimulus and are left to the bench. R6, the absence of any clock dependence, shows only when inputs are driven between edges. R7 needs two mode settings applied to the same operands. Exhaustive coverage needs all 65,536 operand pairs to be swept in each of the four modes.

// File: rtl/cfg_sign_mult.sv
module cfg_sign_mult #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           a_signed,
  input  logic           b_signed,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic          b_top;
  logic [PW-1:0] ext_b;
  logic [PW-1:0] row [W];
  logic [PW-1:0] acc;

  assign b_top = b_signed & b[W-1];
  assign ext_b = {{W{b_top}}, b};

  for (genvar i = 0; i < W; i++) begin : g_row
    assign row[i] = a[i] ? (ext_b << i) : '0;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < W; i++) begin
      if (i == W - 1 && a_signed) acc = acc - row[i];
      else                        acc = acc + row[i];
    end
  end

  assign p = acc;

  logic signed [W:0]    ref_a, ref_b;
  logic signed [PW-1:0] ref_p;

  always_comb begin
    ref_a = a_signed ? {a[W-1], a} : {1'b0, a};
    ref_b = b_signed ? {b[W-1], b} : {1'b0, b};
    ref_p = PW'(ref_a) * PW'(ref_b);
    if (!$isunknown({a, b, a_signed, b_signed})) begin
      if (!a_signed && !b_signed) AST_UNSIGNED_EXACT: assert (p == ref_p); // R1
      if (!a_signed &&  b_signed) AST_B_SIGNED_EXACT: assert (p == ref_p); // R2
      if ( a_signed && !b_signed) AST_A_SIGNED_EXACT: assert (p == ref_p); // R3
      if ( a_signed &&  b_signed) AST_BOTH_SIGNED_EXACT: assert (p == ref_p); // R4
      if (a == '0 || b == '0) AST_ZERO_OPERAND: assert (p == '0); // R5
      if (a_signed && b_signed && a != '0 && b != '0)
        AST_SIGN_OF_PRODUCT: assert (p[PW-1] == (a[W-1] ^ b[W-1])); // R8
    end
  end
endmodule

// File: tb/cfg_sign_mult_bench.sv
module cfg_sign_mult_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  a = '0, b = '0;
  logic        a_signed = 1'b0, b_signed = 1'b0;
  logic [15:0] p;
  int          tests = 0, fails = 0;
  int          cycles = 0;

  cfg_sign_mult u_cfg_sign_mult (
    .a(a), .b(b), .a_signed(a_signed), .b_signed(b_signed), .p(p)
  );

  typedef struct packed {
    logic [7:0]  va;
    logic [7:0]  vb;
    logic        sa;
    logic        sb;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 8'hFF, 1'b0, 1'b0, 16'hFE01, 4'd1}, // R1
    '{8'h0D, 8'h0B, 1'b0, 1'b0, 16'h008F, 4'd1}, // R1
    '{8'h80, 8'h02, 1'b0, 1'b0, 16'h0100, 4'd1}, // R1
    '{8'hFF, 8'hFF, 1'b0, 1'b1, 16'hFF01, 4'd2}, // R2
    '{8'h02, 8'h80, 1'b0, 1'b1, 16'hFF00, 4'd2}, // R2
    '{8'hFF, 8'hFF, 1'b1, 1'b0, 16'hFF01, 4'd3}, // R3
    '{8'h80, 8'hFF, 1'b1, 1'b0, 16'h8080, 4'd3}, // R3
    '{8'h80, 8'h80, 1'b1, 1'b1, 16'h4000, 4'd4}, // R4
    '{8'h80, 8'h7F, 1'b1, 1'b1, 16'hC080, 4'd4}, // R4
    '{8'hFF, 8'hFF, 1'b1, 1'b1, 16'h0001, 4'd4}, // R4
    '{8'h00, 8'hFF, 1'b1, 1'b1, 16'h0000, 4'd5}, // R5
    '{8'hFF, 8'h00, 1'b0, 1'b1, 16'h0000, 4'd5}, // R5
    '{8'h7F, 8'hFF, 1'b0, 1'b0, 16'h7E81, 4'd7}, // R7
    '{8'h7F, 8'hFF, 1'b1, 1'b0, 16'h7E81, 4'd7}  // R7
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: p=%h expected %h (a=%h b=%h as=%b bs=%b)",
               req, got, exp, a, b, a_signed, b_signed);
    end
  endtask

  function automatic logic [15:0] model(input logic [7:0] x, input logic [7:0] y,
                                        input logic sx, input logic sy);
    int ix, iy, prod;
    ix = sx ? int'($signed(x)) : int'(x);
    iy = sy ? int'($signed(y)) : int'(y);
    prod = ix * iy;
    return prod[15:0];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    check("R5 idle", p, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      a = VECS[k].va; b = VECS[k].vb;
      a_signed = VECS[k].sa; b_signed = VECS[k].sb;
      #1;
      check($sformatf("R%0d", VECS[k].req), p, VECS[k].exp);
    end

    // R6: change inputs between edges, sample before the next edge
    @(posedge clk); #1;
    a = 8'h03; b = 8'h05; a_signed = 1'b0; b_signed = 1'b0;
    #1;
    check("R6 same-cycle", p, 16'h000F);

    // R1 R2 R3 R4 R8: exhaustive sweep per mode
    for (int m = 0; m < 4; m++) begin
      int bad = 0;
      logic [15:0] bad_got = '0, bad_exp = '0;
      a_signed = m[1]; b_signed = m[0];
      for (int n = 0; n < 65536; n++) begin
        a = n[7:0]; b = n[15:8];
        #1;
        if (p !== model(a, b, a_signed, b_signed)) begin
          if (bad == 0) begin bad_got = p; bad_exp = model(a, b, a_signed, b_signed); end
          bad++;
        end
        if (m == 3 && a != 0 && b != 0 && p[15] !== (a[7] ^ b[7])) bad++;
      end
      tests++;
      if (bad != 0) begin
        fails++;
        $display("FAIL R%0d sweep mode %0d: first p=%h expected %h, %0d mismatches",
                 m + 1, m, bad_got, bad_exp, bad);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule